// File: doc/BRIEF.md
# HDLC Receive Byte FIFO with Packet-End Tags

This block sits between an HDLC deframer and a host processor and buffers received bytes. Every stored entry holds one data byte plus one tag bit that marks the final byte of a packet. The host always sees the oldest byte and its tag on the read side. It removes that byte with a one-cycle read request. Occupancy is reported as empty and full flags, and four single-cycle event pulses report the conditions a host would turn into interrupts: the FIFO is filling, an overflow happened, a packet end was stored, and a packet end is waiting to be read.

Two host controls change the behaviour. A threshold select moves the filling warning from a nearly-full level to an early level. A soft-reset bit drops every stored byte by moving the read pointer onto the write pointer, so the storage itself is not cleared. While the bit is set, writes are refused. In normal mode a flag seen by the deframer clears the bit. In transparent mode a flag does not clear it, and only a host clear does. Transparent mode also changes overflow: the incoming byte replaces the newest stored byte and reception continues. In normal mode the FIFO stops taking bytes until the next flag.

All state changes happen at the rising clock edge. Each event output is high for exactly the one cycle after the edge at which its cause took effect.

Top module: `hdlc_rx_fifo`

## Requirements
- R1: After reset, empty is 1, full is 0, srst_active is 0 and all four event outputs are 0.
- R2: Bytes and their tags leave in the order they were accepted. rd_data/rd_eop show the oldest entry while empty is 0. empty is 1 exactly at occupancy 0, and full is 1 exactly at occupancy 16.
- R3: In normal mode (transparent=0), a write to a full FIFO with no read in the same cycle pulses ev_ovfl and drops the byte. Every later write is then dropped until a cycle with flag_seen=1.
- R4: In transparent mode, a write to a full FIFO with no read replaces the most recently stored byte and tag and pulses ev_ovfl. The occupancy stays at 16 and later writes are still accepted.
- R5: A read and a write in the same cycle on a full FIFO both take effect. The FIFO stays full and ev_ovfl stays 0.
- R6: With fill_sel=0, ev_fill pulses when the occupancy steps from 14 to 15. With fill_sel=1, it pulses when the occupancy steps from 4 to 5.
- R7: ev_eop_wr pulses when a byte with wr_eop=1 is stored, and this includes a transparent-mode overwrite.
- R8: ev_eop_rd pulses after a read request on an empty FIFO. It also pulses when the oldest entry changes, because of a read or a write into an empty FIFO, and the new oldest entry is tagged.
- R9: A cycle with srst_set=1 leaves the FIFO empty and sets srst_active, and that cycle's read and write are discarded. While srst_active is 1, writes are refused. In normal mode, flag_seen clears srst_active.
- R10: In transparent mode, flag_seen does not clear srst_active. srst_clr clears it in either mode, and srst_set wins over srst_clr in the same cycle.
- R11: A read request on an empty FIFO changes no stored state: the FIFO stays empty and the later output order is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Deframer offers a byte this cycle |
| wr_data | input | 8 | Offered byte |
| wr_eop | input | 1 | Offered byte ends a packet |
| flag_seen | input | 1 | Deframer detected a flag this cycle |
| transparent | input | 1 | Transparent receive mode |
| fill_sel | input | 1 | 1 selects the early filling threshold |
| srst_set | input | 1 | Host sets the soft-reset bit |
| srst_clr | input | 1 | Host clears the soft-reset bit |
| rd_req | input | 1 | Host consumes the oldest byte |
| rd_data | output | 8 | Oldest stored byte |
| rd_eop | output | 1 | Oldest byte ends a packet (0 when empty) |
| empty | output | 1 | Occupancy is zero |
| full | output | 1 | Occupancy is 16 |
| srst_active | output | 1 | Soft-reset bit state |
| ev_fill | output | 1 | Filling threshold crossed |
| ev_ovfl | output | 1 | Write attempted while full |
| ev_eop_wr | output | 1 | Packet-end byte stored |
| ev_eop_rd | output | 1 | Packet end waiting, or empty read |

## Verification
The assertions assume that every control input is a clean synchronous level sampled at the rising edge, that srst_set and srst_clr are single-cycle host actions, and that wr_data and wr_eop are meaningful only while wr_valid is high. The stimulus drives every input half a period away from the active edge. It runs directed sequences for each mode, then a long pseudo-random mix in which reads, writes, flags and soft-reset actions appear at different densities. Empty reads, full-FIFO writes and concurrent read-write are all reached, both in normal mode and in transparent mode.

// File: rtl/hdlc_rx_fifo_pkg.sv
package hdlc_rx_fifo_pkg;

    // Operation applied to the storage in one cycle.
    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_BOTH = 3'd3,
        OP_OVWR = 3'd4,
        OP_DROP = 3'd5
    } fifo_op_e;

endpackage

// File: rtl/hdlc_rx_fifo_ctrl.sv
module hdlc_rx_fifo_ctrl
    import hdlc_rx_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic             rd_req,
    input  logic             flag_seen,
    input  logic             transparent,
    input  logic             srst_set,
    input  logic             srst_clr,
    output fifo_op_e         op,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic [PTR_W-1:0] rd_ptr_q,
    output logic [PTR_W-1:0] rd_ptr_d,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d,
    output logic             srst_q,
    output logic             empty_rd
);

    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] cnt;
        logic             halt;
        logic             srst;
    } ctl_t;

    ctl_t st_d, st_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
        return (p == '0) ? LAST_IDX : p - 1'b1;
    endfunction

    logic accept;
    logic can_pop;
    logic is_full;

    always_comb begin
        st_d     = st_q;
        op       = OP_NONE;
        wr_en    = 1'b0;
        wr_addr  = st_q.wr_ptr;
        accept   = wr_valid && !st_q.halt && !st_q.srst;
        can_pop  = rd_req && (st_q.cnt != '0);
        is_full  = (st_q.cnt == FULL_CNT);
        empty_rd = rd_req && (st_q.cnt == '0);

        if (srst_set) begin
            // Drop the contents by moving the read side onto the write side.
            st_d.cnt    = '0;
            st_d.rd_ptr = st_q.wr_ptr;
            st_d.srst   = 1'b1;
        end else begin
            if (can_pop) begin
                st_d.rd_ptr = ptr_inc(st_q.rd_ptr);
                op          = OP_POP;
            end
            if (accept) begin
                if (!is_full || can_pop) begin
                    wr_en       = 1'b1;
                    st_d.wr_ptr = ptr_inc(st_q.wr_ptr);
                    op          = can_pop ? OP_BOTH : OP_PUSH;
                end else if (transparent) begin
                    wr_en   = 1'b1;
                    wr_addr = ptr_dec(st_q.wr_ptr);
                    op      = OP_OVWR;
                end else begin
                    st_d.halt = 1'b1;
                    op        = OP_DROP;
                end
            end
            unique case (op)
                OP_PUSH: st_d.cnt = st_q.cnt + 1'b1;
                OP_POP:  st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
            if (srst_clr || (flag_seen && !transparent)) begin
                st_d.srst = 1'b0;
            end
        end

        if (flag_seen) begin
            st_d.halt = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_ptr_q = st_q.rd_ptr;
    assign rd_ptr_d = st_d.rd_ptr;
    assign cnt_q    = st_q.cnt;
    assign cnt_d    = st_d.cnt;
    assign srst_q   = st_q.srst;

endmodule

// File: rtl/hdlc_rx_fifo_mem.sv
module hdlc_rx_fifo_mem #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned ENT_W = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [ENT_W-1:0]  wr_word,
    input  logic [PTR_W-1:0]  head_addr,
    input  logic [PTR_W-1:0]  peek_addr,
    output logic [ENT_W-1:0]  head_word,
    output logic [ENT_W-1:0]  peek_word
);

    logic [ENT_W-1:0] ent_d [DEPTH];
    logic [ENT_W-1:0] ent_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_comb begin
            ent_d[i] = ent_q[i];
            if (wr_en && (wr_addr == PTR_W'(i))) begin
                ent_d[i] = wr_word;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q[i] <= '0;
            end else begin
                ent_q[i] <= ent_d[i];
            end
        end
    end

    assign head_word = ent_q[head_addr];
    assign peek_word = ent_q[peek_addr];

endmodule

// File: rtl/hdlc_rx_fifo_evt.sv
module hdlc_rx_fifo_evt
    import hdlc_rx_fifo_pkg::*;
#(
    parameter int unsigned DEPTH   = 16,
    parameter int unsigned FILL_HI = 15,
    parameter int unsigned FILL_LO = 5,
    localparam int unsigned PTR_W  = $clog2(DEPTH),
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_sel,
    input  fifo_op_e         op,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] cnt_d,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_addr,
    input  logic             wr_eop,
    input  logic [PTR_W-1:0] rd_ptr_d,
    input  logic             peek_eop,
    input  logic             empty_rd,
    output logic             ev_fill,
    output logic             ev_ovfl,
    output logic             ev_eop_wr,
    output logic             ev_eop_rd
);

    localparam logic [CNT_W-1:0] THR_HI = CNT_W'(FILL_HI);
    localparam logic [CNT_W-1:0] THR_LO = CNT_W'(FILL_LO);

    typedef struct packed {
        logic fill;
        logic ovfl;
        logic eop_wr;
        logic eop_rd;
    } evt_t;

    evt_t ev_d, ev_q;

    logic [CNT_W-1:0] thr;
    logic             head_moved;
    logic             new_head_eop;

    always_comb begin
        thr          = fill_sel ? THR_LO : THR_HI;
        head_moved   = (op == OP_POP) || (op == OP_BOTH) ||
                       ((op == OP_PUSH) && (cnt_q == '0));
        new_head_eop = (wr_en && (wr_addr == rd_ptr_d)) ? wr_eop : peek_eop;

        ev_d.fill   = (cnt_q == thr - 1'b1) && (cnt_d == thr);
        ev_d.ovfl   = (op == OP_OVWR) || (op == OP_DROP);
        ev_d.eop_wr = wr_en && wr_eop;
        ev_d.eop_rd = empty_rd || (head_moved && (cnt_d != '0) && new_head_eop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q <= '0;
        end else begin
            ev_q <= ev_d;
        end
    end

    assign ev_fill   = ev_q.fill;
    assign ev_ovfl   = ev_q.ovfl;
    assign ev_eop_wr = ev_q.eop_wr;
    assign ev_eop_rd = ev_q.eop_rd;

endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo
    import hdlc_rx_fifo_pkg::*;
#(
    parameter int unsigned DEPTH   = 16,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned FILL_HI = 15,
    parameter int unsigned FILL_LO = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_eop,
    input  logic              flag_seen,
    input  logic              transparent,
    input  logic              fill_sel,
    input  logic              srst_set,
    input  logic              srst_clr,
    input  logic              rd_req,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_eop,
    output logic              empty,
    output logic              full,
    output logic              srst_active,
    output logic              ev_fill,
    output logic              ev_ovfl,
    output logic              ev_eop_wr,
    output logic              ev_eop_rd
);

    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam int unsigned ENT_W = DATA_W + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    fifo_op_e         op;
    logic             wr_en;
    logic [PTR_W-1:0] wr_addr;
    logic [PTR_W-1:0] rd_ptr_q;
    logic [PTR_W-1:0] rd_ptr_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             srst_q;
    logic             empty_rd;
    logic [ENT_W-1:0] head_word;
    logic [ENT_W-1:0] peek_word;

    hdlc_rx_fifo_ctrl #(.DEPTH(DEPTH)) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_valid    (wr_valid),
        .rd_req      (rd_req),
        .flag_seen   (flag_seen),
        .transparent (transparent),
        .srst_set    (srst_set),
        .srst_clr    (srst_clr),
        .op          (op),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .rd_ptr_q    (rd_ptr_q),
        .rd_ptr_d    (rd_ptr_d),
        .cnt_q       (cnt_q),
        .cnt_d       (cnt_d),
        .srst_q      (srst_q),
        .empty_rd    (empty_rd)
    );

    hdlc_rx_fifo_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_word   ({wr_eop, wr_data}),
        .head_addr (rd_ptr_q),
        .peek_addr (rd_ptr_d),
        .head_word (head_word),
        .peek_word (peek_word)
    );

    hdlc_rx_fifo_evt #(
        .DEPTH   (DEPTH),
        .FILL_HI (FILL_HI),
        .FILL_LO (FILL_LO)
    ) i_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_sel  (fill_sel),
        .op        (op),
        .cnt_q     (cnt_q),
        .cnt_d     (cnt_d),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_eop    (wr_eop),
        .rd_ptr_d  (rd_ptr_d),
        .peek_eop  (peek_word[DATA_W]),
        .empty_rd  (empty_rd),
        .ev_fill   (ev_fill),
        .ev_ovfl   (ev_ovfl),
        .ev_eop_wr (ev_eop_wr),
        .ev_eop_rd (ev_eop_rd)
    );

    assign empty       = (cnt_q == '0);
    assign full        = (cnt_q == FULL_CNT);
    assign rd_data     = head_word[DATA_W-1:0];
    assign rd_eop      = !empty && head_word[DATA_W];
    assign srst_active = srst_q;

endmodule

// File: rtl/hdlc_rx_fifo_chk.sv
module hdlc_rx_fifo_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_valid,
    input logic rd_req,
    input logic srst_set,
    input logic empty,
    input logic full,
    input logic srst_active,
    input logic ev_fill,
    input logic ev_ovfl,
    input logic ev_eop_wr,
    input logic ev_eop_rd
);

    p_full_empty_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    p_ovfl_from_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ovfl |-> ($past(full) && full));

    p_rdwr_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_valid && rd_req && !srst_set) |=> !ev_ovfl);

    p_fill_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_fill |-> (!empty && !full));

    p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_req) |=> ev_eop_rd);

    p_srst_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        srst_set |=> (empty && srst_active));

    p_srst_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        srst_active |=> !ev_eop_wr);

endmodule

bind hdlc_rx_fifo hdlc_rx_fifo_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .rd_req      (rd_req),
    .srst_set    (srst_set),
    .empty       (empty),
    .full        (full),
    .srst_active (srst_active),
    .ev_fill     (ev_fill),
    .ev_ovfl     (ev_ovfl),
    .ev_eop_wr   (ev_eop_wr),
    .ev_eop_rd   (ev_eop_rd)
);

// File: tb/test_hdlc_rx_fifo.sv
module test_hdlc_rx_fifo;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_eop = 1'b0;
    logic       flag_seen = 1'b0;
    logic       transparent = 1'b0;
    logic       fill_sel = 1'b0;
    logic       srst_set = 1'b0;
    logic       srst_clr = 1'b0;
    logic       rd_req = 1'b0;
    logic [7:0] rd_data;
    logic       rd_eop, empty, full, srst_active;
    logic       ev_fill, ev_ovfl, ev_eop_wr, ev_eop_rd;

    always #10 clk = ~clk;

    hdlc_rx_fifo i_hdlc_rx_fifo (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_eop(wr_eop), .flag_seen(flag_seen), .transparent(transparent),
        .fill_sel(fill_sel), .srst_set(srst_set), .srst_clr(srst_clr),
        .rd_req(rd_req), .rd_data(rd_data), .rd_eop(rd_eop), .empty(empty),
        .full(full), .srst_active(srst_active), .ev_fill(ev_fill),
        .ev_ovfl(ev_ovfl), .ev_eop_wr(ev_eop_wr), .ev_eop_rd(ev_eop_rd)
    );

    int checks = 0;
    int fails  = 0;
    int fill_pulses = 0;
    int last_pop = -1;

    // Reference model: queue of {eop, data}
    int q[$];
    bit m_halt = 0, m_srst = 0;
    bit x_fill = 0, x_ovfl = 0, x_eopwr = 0, x_eoprd = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic compare();
        chk(empty == (q.size() == 0), "R2 empty", empty, q.size() == 0);
        chk(full == (q.size() == 16), "R2 full", full, q.size() == 16);
        if (q.size() != 0) begin
            chk({rd_eop, rd_data} == q[0][8:0], "R2 head word", {rd_eop, rd_data}, q[0]);
        end else begin
            chk(rd_eop == 1'b0, "R2 tag when empty", rd_eop, 0);
        end
        chk(ev_ovfl == x_ovfl, "R3 ev_ovfl", ev_ovfl, x_ovfl);
        chk(ev_fill == x_fill, "R6 ev_fill", ev_fill, x_fill);
        chk(ev_eop_wr == x_eopwr, "R7 ev_eop_wr", ev_eop_wr, x_eopwr);
        chk(ev_eop_rd == x_eoprd, "R8 ev_eop_rd", ev_eop_rd, x_eoprd);
        chk(srst_active == m_srst, "R9 srst_active", srst_active, m_srst);
        if (ev_fill) fill_pulses++;
    endtask

    // One clock: drive at the falling edge, update model, check at the next falling edge.
    task automatic cyc(input bit w, input int d, input bit e, input bit r,
                       input bit f = 0, input bit ss = 0, input bit sc = 0);
        int  old_n;
        bit  pop, moved;
        int  thr;
        wr_valid = w; wr_data = d[7:0]; wr_eop = e; rd_req = r;
        flag_seen = f; srst_set = ss; srst_clr = sc;
        old_n = q.size();
        x_fill = 0; x_ovfl = 0; x_eopwr = 0; x_eoprd = (r && old_n == 0);
        moved = 0;
        if (ss) begin
            q.delete();
            m_srst = 1;
        end else begin
            pop = r && old_n > 0;
            if (pop) begin
                last_pop = q.pop_front();
                moved = 1;
            end
            if (w && !m_halt && !m_srst) begin
                if (old_n < 16 || pop) begin
                    q.push_back({e, d[7:0]});
                    if (old_n == 0) moved = 1;
                    x_eopwr = e;
                end else begin
                    x_ovfl = 1;
                    if (transparent) begin
                        q[q.size() - 1] = {e, d[7:0]};
                        x_eopwr = e;
                    end else begin
                        m_halt = 1;
                    end
                end
            end
            if (sc || (f && !transparent)) m_srst = 0;
        end
        if (f) m_halt = 0;
        thr = fill_sel ? 5 : 15;
        x_fill = (old_n == thr - 1) && (q.size() == thr);
        if (moved && q.size() > 0 && q[0][8]) x_eoprd = 1;
        @(posedge clk);
        @(negedge clk);
        compare();
        wr_valid = 0; rd_req = 0; flag_seen = 0; srst_set = 0; srst_clr = 0;
    endtask

    task automatic drain();
        while (q.size() > 0) cyc(0, 0, 0, 1);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int lfsr;
        int fp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(empty == 1'b1, "R1 empty after reset", empty, 1);
        chk(full == 1'b0, "R1 full after reset", full, 0);
        chk(srst_active == 1'b0, "R1 srst_active after reset", srst_active, 0);
        chk({ev_fill, ev_ovfl, ev_eop_wr, ev_eop_rd} == 4'b0, "R1 events after reset",
            {ev_fill, ev_ovfl, ev_eop_wr, ev_eop_rd}, 0);

        // R2, R7, R8: a short packet
        cyc(1, 8'hA0, 0, 0);
        cyc(1, 8'hA1, 0, 0);
        cyc(1, 8'hA2, 1, 0);
        chk(rd_data == 8'hA0, "R2 oldest byte first", rd_data, 8'hA0);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 1);
        chk(ev_eop_rd == 1'b1 && rd_eop == 1'b1, "R8 tagged head reached", ev_eop_rd, 1);
        cyc(0, 0, 0, 1);
        // R11: empty read leaves state unchanged
        cyc(0, 0, 0, 1);
        chk(empty == 1'b1 && ev_eop_rd == 1'b1, "R11 empty read keeps empty", empty, 1);
        cyc(1, 8'h5A, 0, 0);
        chk(rd_data == 8'h5A, "R11 order intact after empty read", rd_data, 8'h5A);
        drain();

        // R6 high threshold and R3 normal overflow
        fill_sel = 0;
        fill_pulses = 0;
        for (int i = 0; i < 16; i++) cyc(1, 8'h10 + i, 0, 0);
        chk(fill_pulses == 1, "R6 one pulse at 15", fill_pulses, 1);
        cyc(1, 8'hFF, 1, 0);
        chk(ev_ovfl == 1'b1 && ev_eop_wr == 1'b0, "R3 overflow flagged, byte dropped", ev_ovfl, 1);
        cyc(0, 0, 0, 1);
        cyc(1, 8'hFE, 0, 0);
        chk(full == 1'b0, "R3 write refused while halted", full, 0);
        cyc(0, 0, 0, 0, 1);
        cyc(1, 8'h77, 0, 0);
        chk(full == 1'b1, "R3 flag resumes reception", full, 1);
        // R5 concurrent read and write while full
        cyc(1, 8'h78, 0, 1);
        chk(full == 1'b1 && ev_ovfl == 1'b0, "R5 full read+write", ev_ovfl, 0);
        drain();
        chk(last_pop == 8'h78, "R5 concurrent byte kept", last_pop, 8'h78);

        // R6 low threshold
        fill_sel = 1;
        fill_pulses = 0;
        for (int i = 0; i < 6; i++) cyc(1, 8'h30 + i, 0, 0);
        chk(fill_pulses == 1, "R6 one pulse at 5", fill_pulses, 1);
        drain();
        fill_sel = 0;

        // R4 transparent overwrite
        transparent = 1;
        for (int i = 0; i < 16; i++) cyc(1, 8'h40 + i, 0, 0);
        cyc(1, 8'hEE, 0, 0);
        cyc(1, 8'hEF, 1, 0);
        chk(ev_ovfl == 1'b1 && ev_eop_wr == 1'b1 && full == 1'b1,
            "R4 overwrite flagged and stored", ev_ovfl, 1);
        drain();
        chk(last_pop == 9'h1EF, "R4 newest entry replaced", last_pop, 9'h1EF);
        transparent = 0;

        // R9 soft reset, normal mode
        cyc(1, 8'h01, 0, 0);
        cyc(1, 8'h02, 0, 0);
        cyc(0, 0, 0, 0, 0, 1);
        chk(empty == 1'b1 && srst_active == 1'b1, "R9 soft reset empties", empty, 1);
        cyc(1, 8'h03, 1, 0);
        chk(empty == 1'b1 && ev_eop_wr == 1'b0, "R9 write refused", empty, 1);
        cyc(0, 0, 0, 0, 1);
        chk(srst_active == 1'b0, "R9 flag clears soft reset", srst_active, 0);
        cyc(1, 8'h04, 0, 0);
        chk(rd_data == 8'h04, "R9 reception restarts", rd_data, 8'h04);
        drain();

        // R10 soft reset, transparent mode
        transparent = 1;
        cyc(0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 1);
        chk(srst_active == 1'b1, "R10 flag ignored in transparent", srst_active, 1);
        cyc(0, 0, 0, 0, 0, 1, 1);
        chk(srst_active == 1'b1, "R10 set wins over clear", srst_active, 1);
        cyc(0, 0, 0, 0, 0, 0, 1);
        chk(srst_active == 1'b0, "R10 host clear", srst_active, 0);
        cyc(1, 8'h99, 0, 0);
        chk(empty == 1'b0, "R10 reception after clear", empty, 0);
        drain();
        transparent = 0;

        // Mixed traffic against the model
        lfsr = 32'h1ACE_B00C;
        for (int n = 0; n < 6000; n++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >>> 17);
            lfsr = lfsr ^ (lfsr << 5);
            if ((n % 1500) == 0) transparent = ~transparent;
            if ((n % 700) == 0) fill_sel = ~fill_sel;
            fp = (n / 400) % 3;
            cyc(lfsr[0] | (fp == 0 ? lfsr[1] : 1'b0),
                lfsr[15:8], lfsr[20] & lfsr[21],
                fp == 2 ? (lfsr[2] | lfsr[3]) : (lfsr[2] & lfsr[3]),
                lfsr[26:23] == 4'h0,
                lfsr[31:26] == 6'h3F,
                lfsr[31:26] == 6'h15);
        end

        summary();
        $finish;
    end

endmodule